// File: doc/BRIEF.md
# Grouped Decimal Carry-Lookahead Adder

This block adds two unsigned packed-decimal operands of a parameterised digit count, plus a one-bit carry-in. It returns the decimal sum of the same width and a decimal carry-out. Every digit is held in 8421 form, four bits per digit, with the least significant digit in bits 3:0.

Each digit cell flags whether its two operand digits alone produce a decimal carry (generate, digit sum above nine) or would pass an incoming carry through (propagate, digit sum exactly nine). Digits are bundled four to a group. Each group resolves its internal carries and its outgoing carry by lookahead over these flags instead of rippling from digit to digit. A cell corrects any binary digit total above nine back into the range 0..9 and raises a decimal carry.

Operands enter on a valid/ready stream and the result leaves on another one. With the output register enabled, one result can be held and back-pressure applies: the input is ready whenever the output register is empty or is being drained in the same cycle. With the register disabled, the block is purely combinational. In that case the valid and ready signals pass straight through between the two sides.

Top module: `bcd_cla_adder`

## Requirements
- R1: `out_sum` holds (A + B + `in_carry`) mod 10^DIGITS, where decimal digit i of every operand and of the sum lies in bits 4i+3:4i, coded 8421 (0000 = 0 ... 1001 = 9).
- R2: `out_carry` is 1 exactly when A + B + `in_carry` is at least 10^DIGITS.
- R3: For valid operand digits, every 4-bit digit of `out_sum` lies in 0..9; digit totals of 10..19 are reduced by ten with a carry into the next digit.
- R4: Operand A all nines, B zero, carry-in 1 gives a sum of all zeros and a carry-out of 1, so the carry crosses every group.
- R5: Operand A all nines, B zero, carry-in 0 gives all nines and a carry-out of 0, since propagate alone never creates a carry.
- R6: A carry generated in one group reaches digits in later groups through the group generate/propagate terms; the carry out of group g equals its generate OR (its propagate AND the carry into it).
- R7: With the output register enabled, a transfer accepted when `in_valid` and `in_ready` are both 1 at a clock edge appears with `out_valid` = 1 after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`. Results leave in acceptance order.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sum` and `out_carry` stay unchanged.
- R9: While `rst_n` is 0 and just after its release, `out_valid` is 0 and `in_ready` is 1.
- R10: With the output register disabled, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the sum is available in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Block can take operands this cycle |
| in_a | input | 4*DIGITS | Operand A, packed 8421 digits |
| in_b | input | 4*DIGITS | Operand B, packed 8421 digits |
| in_carry | input | 1 | Decimal carry-in |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 4*DIGITS | Decimal sum, packed 8421 digits |
| out_carry | output | 1 | Decimal carry-out |

## Verification
The main instance is built with sixteen digits (four lookahead groups) and the output register enabled. At that size, carries that cross three group boundaries and stalls of the output stage from a randomly toggled consumer ready are both within reach. A second instance is built with eight digits and no register, which exercises the combinational pass-through and a two-group chain. Expected values come from integer arithmetic on the decoded operands. The directed all-nines cases fix the ends of the carry chain.

// File: rtl/bcd_cla_pkg.sv
package bcd_cla_pkg;
  localparam int unsigned DIGIT_BITS = 4;
  localparam int unsigned GROUP_DIGITS = 4;
  localparam int unsigned GROUP_BITS = DIGIT_BITS * GROUP_DIGITS;

  typedef logic [DIGIT_BITS-1:0] bcd_digit_t;
  typedef logic [GROUP_BITS-1:0] bcd_group_t;

  function automatic logic digit_is_valid(input bcd_digit_t d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_cla_pkg::*;
(
  input  bcd_digit_t op_a,
  input  bcd_digit_t op_b,
  input  logic       carry_in,
  output bcd_digit_t digit_sum,
  output logic       carry_out,
  output logic       dgen,
  output logic       dprop
);
  logic [4:0] raw_sum;
  logic [4:0] full_sum;
  logic [4:0] fixed_sum;

  always_comb begin
    raw_sum   = {1'b0, op_a} + {1'b0, op_b};
    full_sum  = raw_sum + {4'd0, carry_in};
    fixed_sum = full_sum + 5'd6;
    dgen      = raw_sum > 5'd9;
    dprop     = raw_sum == 5'd9;
    carry_out = full_sum > 5'd9;
    digit_sum = carry_out ? fixed_sum[3:0] : full_sum[3:0];
  end
endmodule

// File: rtl/bcd_lookahead_group.sv
module bcd_lookahead_group
  import bcd_cla_pkg::*;
(
  input  bcd_group_t              grp_a,
  input  bcd_group_t              grp_b,
  input  logic                    grp_cin,
  output bcd_group_t              grp_sum,
  output logic                    grp_cout,
  output logic                    grp_gen,
  output logic                    grp_prop,
  output logic [GROUP_DIGITS-1:0] la_carry,
  output logic [GROUP_DIGITS-1:0] cell_carry
);
  logic [GROUP_DIGITS-1:0] dg;
  logic [GROUP_DIGITS-1:0] dp;
  logic [GROUP_DIGITS:0]   cin_vec;

  for (genvar d = 0; d < GROUP_DIGITS; d++) begin : g_cell
    bcd_digit_cell u_cell (
      .op_a     (grp_a[d*DIGIT_BITS +: DIGIT_BITS]),
      .op_b     (grp_b[d*DIGIT_BITS +: DIGIT_BITS]),
      .carry_in (cin_vec[d]),
      .digit_sum(grp_sum[d*DIGIT_BITS +: DIGIT_BITS]),
      .carry_out(cell_carry[d]),
      .dgen     (dg[d]),
      .dprop    (dp[d])
    );
  end

  // Each digit carry is a flat sum of products over the flags below it.
  always_comb begin
    cin_vec[0] = grp_cin;
    for (int i = 0; i < GROUP_DIGITS; i++) begin
      logic acc;
      logic term;
      term = grp_cin;
      for (int j = 0; j <= i; j++) term = term & dp[j];
      acc = term;
      for (int j = 0; j <= i; j++) begin
        term = dg[j];
        for (int k = j + 1; k <= i; k++) term = term & dp[k];
        acc = acc | term;
      end
      cin_vec[i+1] = acc;
    end
  end

  always_comb begin
    grp_prop = &dp;
    grp_gen  = dg[3] | (dp[3] & dg[2]) | (dp[3] & dp[2] & dg[1])
             | (dp[3] & dp[2] & dp[1] & dg[0]);
    grp_cout = cin_vec[GROUP_DIGITS];
    la_carry = cin_vec[GROUP_DIGITS:1];
  end
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
  parameter int unsigned WIDTH   = 65,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [WIDTH-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [WIDTH-1:0] m_data
);
  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [WIDTH-1:0] dat_q;
    assign s_ready = !vld_q || m_ready;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (s_ready) begin
        vld_q <= s_valid;
        if (s_valid) dat_q <= s_data;
      end
    end
    assign m_valid = vld_q;
    assign m_data  = dat_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign s_ready = m_ready;
    assign m_valid = s_valid;
    assign m_data  = s_data;
  end
endmodule

// File: rtl/bcd_cla_adder.sv
module bcd_cla_adder
  import bcd_cla_pkg::*;
#(
  parameter int unsigned DIGITS  = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DIGIT_BITS*DIGITS-1:0] in_a,
  input  logic [DIGIT_BITS*DIGITS-1:0] in_b,
  input  logic                         in_carry,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DIGIT_BITS*DIGITS-1:0] out_sum,
  output logic                         out_carry
);
  localparam int unsigned NGROUPS = DIGITS / GROUP_DIGITS;
  localparam int unsigned SUM_W   = DIGIT_BITS * DIGITS;

  initial begin
    if (DIGITS % GROUP_DIGITS != 0 || DIGITS == 0)
      $error("DIGITS must be a nonzero multiple of %0d", GROUP_DIGITS);
  end

  logic [NGROUPS:0]   grp_c;
  logic [NGROUPS-1:0] grp_g;
  logic [NGROUPS-1:0] grp_p;
  logic [DIGITS-1:0]  la_carry_all;
  logic [DIGITS-1:0]  cell_carry_all;
  logic [SUM_W-1:0]   comb_sum;

  assign grp_c[0] = in_carry;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    bcd_lookahead_group u_grp (
      .grp_a     (in_a[g*GROUP_BITS +: GROUP_BITS]),
      .grp_b     (in_b[g*GROUP_BITS +: GROUP_BITS]),
      .grp_cin   (grp_c[g]),
      .grp_sum   (comb_sum[g*GROUP_BITS +: GROUP_BITS]),
      .grp_cout  (grp_c[g+1]),
      .grp_gen   (grp_g[g]),
      .grp_prop  (grp_p[g]),
      .la_carry  (la_carry_all[g*GROUP_DIGITS +: GROUP_DIGITS]),
      .cell_carry(cell_carry_all[g*GROUP_DIGITS +: GROUP_DIGITS])
    );
  end

  bcd_out_stage #(.WIDTH(SUM_W + 1), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data ({grp_c[NGROUPS], comb_sum}),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data ({out_carry, out_sum})
  );
endmodule

// File: rtl/bcd_cla_adder_chk.sv
module bcd_cla_adder_chk #(
  parameter int unsigned DIGITS  = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [4*DIGITS-1:0]   out_sum,
  input logic                  out_carry,
  input logic [DIGITS/4:0]     grp_c,
  input logic [DIGITS/4-1:0]   grp_g,
  input logic [DIGITS/4-1:0]   grp_p,
  input logic [DIGITS-1:0]     la_carry_all,
  input logic [DIGITS-1:0]     cell_carry_all
);
  localparam int unsigned NG = DIGITS / 4;

  function automatic logic all_digits_ok(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R6: corrected cell carries agree with the lookahead network
  assert_cell_vs_lookahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cell_carry_all == la_carry_all);

  for (genvar g = 0; g < NG; g++) begin : g_pg
    // R6: group carry out from generate/propagate
    assert_group_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_c[g+1] == (grp_g[g] | (grp_p[g] & grp_c[g])));
  end

  if (REG_OUT) begin : g_reg_chk
    // R3: held results carry valid digits
    assert_valid_digits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> all_digits_ok(out_sum));
    // R8: stalled output holds
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)));
    // R7: an accepted transfer is presented after the edge
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
  end
endmodule

bind bcd_cla_adder bcd_cla_adder_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_sum       (out_sum),
  .out_carry     (out_carry),
  .grp_c         (grp_c),
  .grp_g         (grp_g),
  .grp_p         (grp_p),
  .la_carry_all  (la_carry_all),
  .cell_carry_all(cell_carry_all)
);

// File: tb/bcd_cla_adder_test.sv
module bcd_cla_adder_test;
  localparam int ND  = 16;
  localparam int NDC = 8;

  typedef struct {
    logic [4*ND-1:0] sum;
    logic            cy;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4*ND-1:0] in_a = '0;
  logic [4*ND-1:0] in_b = '0;
  logic in_carry = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [4*ND-1:0] out_sum;
  logic out_carry;

  logic c_valid = 1'b0;
  logic c_iready;
  logic [4*NDC-1:0] c_a = '0;
  logic [4*NDC-1:0] c_b = '0;
  logic c_cin = 1'b0;
  logic c_ovalid;
  logic c_oready = 1'b0;
  logic [4*NDC-1:0] c_sum;
  logic c_cout;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int received = 0;
  bit driving_done = 1'b0;
  bit run_monitor = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  bcd_cla_adder #(.DIGITS(ND), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry));

  bcd_cla_adder #(.DIGITS(NDC), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_ready(c_iready),
    .in_a(c_a), .in_b(c_b), .in_carry(c_cin), .out_valid(c_ovalid),
    .out_ready(c_oready), .out_sum(c_sum), .out_carry(c_cout));

  function automatic longint to_int(input logic [4*ND-1:0] v, input int nd);
    longint r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [4*ND-1:0] to_bcd(input longint x, input int nd);
    logic [4*ND-1:0] r = '0;
    longint t = x;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic longint pow10(input int nd);
    longint p = 1;
    for (int i = 0; i < nd; i++) p = p * 10;
    return p;
  endfunction

  function automatic logic [4*ND-1:0] rand_bcd(input int nd);
    logic [4*ND-1:0] r = '0;
    for (int i = 0; i < nd; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4*ND-1:0] a, input logic [4*ND-1:0] b,
                      input logic c, input string tag);
    exp_t e;
    longint tot;
    tot = to_int(a, ND) + to_int(b, ND) + longint'(c);
    e.cy  = tot >= pow10(ND);
    e.sum = to_bcd(tot % pow10(ND), ND);
    e.tag = tag;
    @(negedge clk);
    in_a = a; in_b = b; in_carry = c; in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    sb.push_back(e);
    sent++;
    @(negedge clk);
    in_valid = ($urandom % 4) == 0 ? 1'b0 : 1'b1;
    in_valid = 1'b0;
  endtask

  // Monitor: sets consumer ready at the falling edge, samples after settling.
  initial begin
    wait (run_monitor);
    forever begin
      @(negedge clk);
      out_ready = driving_done ? 1'b1 : (($urandom % 3) != 0);
      #1;
      // R7: ready rule of the output register
      check(in_ready == (!out_valid || out_ready), "R7 in_ready rule",
            longint'(in_ready), longint'(!out_valid || out_ready));
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 result without accepted transfer", 1, 0);
        end else begin
          exp_t e;
          bit dig_ok;
          e = sb[0];
          dig_ok = 1'b1;
          for (int i = 0; i < ND; i++) if (out_sum[4*i +: 4] > 4'd9) dig_ok = 1'b0;
          if (!out_ready) begin
            // R8: stalled output must still match the pending result
            check(out_sum == e.sum && out_carry == e.cy, "R8 stalled hold",
                  longint'(out_sum), longint'(e.sum));
          end else begin
            void'(sb.pop_front());
            received++;
            check(out_sum == e.sum, {e.tag, " R1 sum"}, longint'(out_sum), longint'(e.sum));
            check(out_carry == e.cy, {e.tag, " R2 carry"}, longint'(out_carry), longint'(e.cy));
            check(dig_ok, {e.tag, " R3 digits in range"}, longint'(out_sum), longint'(e.sum));
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [4*ND-1:0] nines;
    logic [4*ND-1:0] v;
    nines = '0;
    for (int i = 0; i < ND; i++) nines[4*i +: 4] = 4'd9;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after release", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after release", longint'(in_ready), 1);
    run_monitor = 1'b1;

    send('0, '0, 1'b0, "zero");
    send(nines, '0, 1'b1, "R4 all nines plus carry");
    send(nines, '0, 1'b0, "R5 all nines no carry");
    // R6: nines in digits 0..6 plus one crosses the group at digit 4
    v = '0;
    for (int i = 0; i < 7; i++) v[4*i +: 4] = 4'd9;
    send(v, 64'd1, 1'b0, "R6 carry across group");
    // R6: generate in group 0, propagate through groups 1..3
    v = nines;
    v[3:0] = 4'd5;
    send(v, 64'd5, 1'b0, "R6 carry through all groups");
    send(nines, nines, 1'b1, "R2 max operands");
    send(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, 1'b0, "R3 digit correction");
    for (int n = 0; n < 300; n++)
      send(rand_bcd(ND), rand_bcd(ND), 1'($urandom % 2), "random");

    driving_done = 1'b1;
    repeat (6) @(negedge clk);
    check(sb.size() == 0 && received == sent, "R7 all results delivered in order",
          longint'(received), longint'(sent));

    // R10: combinational variant
    for (int n = 0; n < 40; n++) begin
      longint tot;
      logic [4*ND-1:0] ea;
      logic [4*ND-1:0] eb;
      logic vv;
      logic rr;
      ea = rand_bcd(NDC);
      eb = rand_bcd(NDC);
      if (n == 0) begin
        ea = '0;
        for (int i = 0; i < NDC; i++) ea[4*i +: 4] = 4'd9;
        eb = '0;
      end
      vv = 1'($urandom % 2);
      rr = 1'($urandom % 2);
      @(negedge clk);
      c_a = ea[4*NDC-1:0];
      c_b = eb[4*NDC-1:0];
      c_cin = (n == 0) ? 1'b1 : 1'($urandom % 2);
      c_valid = vv;
      c_oready = rr;
      #1;
      tot = to_int(ea, NDC) + to_int(eb, NDC) + longint'(c_cin);
      check(c_ovalid == vv && c_iready == rr, "R10 handshake pass-through",
            longint'({c_ovalid, c_iready}), longint'({vv, rr}));
      check(c_sum == 32'(to_bcd(tot % pow10(NDC), NDC)), "R10 R1 same-cycle sum",
            longint'(c_sum), tot % pow10(NDC));
      check(c_cout == (tot >= pow10(NDC)), "R10 R2 same-cycle carry",
            longint'(c_cout), longint'(tot >= pow10(NDC)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule